// File: doc/BRIEF.md
# Counter Compare-Match Event Unit

This unit sits beside a free-running up-counter and turns it into a source of one-shot timed events without ever stopping or clearing it. Software reads the live count, adds the delay it wants modulo 2^32, writes the sum into one of several compare slots and sets that slot's enable bit. When the counter steps onto that value, the unit raises its compare interrupt for one clock. The same counter keeps serving as the system time base throughout.

Each slot is armed by a write to its compare value and disarms itself when it fires, so it gives a single event per write. Periodic events need a fresh write after every match. A slot whose enable bit is clear never fires but keeps its arming, so setting the bit later lets it fire at the next occurrence of the value. Only a change of the counter can cause a match. A counter that holds still on a matching value, or a compare value written equal to the count already present, raises nothing.

Top module: `cmevt_top`

## Requirements
- R1: After reset every compare slot reads 0, the enable register reads 0, and `cmp_irq` is low.
- R2: Compare slot i sits at byte address 0x60 + 4*i (i = 0..7). A write there stores the full 32-bit value, reads return it, and the write arms that slot.
- R3: The enable register sits at byte address 0x80. Bit i enables slot i. Bits 31..8 ignore writes and read as 0.
- R4: When `count_in` at a rising edge differs from its value at the previous edge and equals the value of a slot that is armed and enabled, `cmp_irq` is high during the following clock cycle.
- R5: A slot that fires is disarmed. A later recurrence of its value raises nothing until the slot is written again. A write in the same cycle as the match leaves the slot armed with the new value.
- R6: A slot whose enable bit is 0 never fires and keeps its arming. Once it is enabled, the next change onto its value fires.
- R7: A counter that holds still causes no match. Writing a compare value equal to the current, unchanging count raises nothing.
- R8: Matching is plain 32-bit equality, so a target computed as count + delta with wraparound past 0xFFFFFFFF fires at the correct wrapped value.
- R9: Several slots matching on the same transition give one single-cycle pulse and all of them disarm. Distinct slots fire on their own transitions.
- R10: Writes to any other address, including unaligned ones such as 0x62, change no register. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| count_in | input | 32 | Live value of the free-running counter |
| cmp_irq | output | 1 | One-cycle compare-match interrupt pulse |

## Verification
A wrong slot state shows up at the interrupt line. A lost arm, a missing clear after a match or a dropped enable bit either removes a pulse or adds one on the very next counter transition onto that value. A stale sampled counter shows up as a pulse on a cycle where the count held still, or as a missing pulse right after a change. Compare storage and the enable register are visible through reads, and an address-decode fault shows in the readback of the first register it corrupts.

// File: rtl/cmevt_pkg.sv
package cmevt_pkg;
   // Selects how the interrupt leaves the block.
   typedef enum logic {
      IRQ_COMB       = 1'b0,
      IRQ_REGISTERED = 1'b1
   } cmevt_irq_style_e;

   // Kind of register the bus address points at.
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_SLOT = 2'd1,
      ACC_EN   = 2'd2
   } cmevt_acc_e;
endpackage

// File: rtl/cmevt_decode.sv
module cmevt_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM_CMP   = 8,
   parameter int SLOT_BASE = 'h60,
   parameter int EN_OFF    = 'h80
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_CMP-1:0] sel_slot,
   output logic               sel_en,
   output cmevt_pkg::cmevt_acc_e acc_kind
);
   localparam int STRIDE = 4;

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_dec
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(SLOT_BASE + STRIDE * i);
      assign sel_slot[i] = (addr == SLOT_ADDR);
   end

   assign sel_en = (addr == ADDR_W'(EN_OFF));

   always_comb begin
      if (|sel_slot)   acc_kind = cmevt_pkg::ACC_SLOT;
      else if (sel_en) acc_kind = cmevt_pkg::ACC_EN;
      else             acc_kind = cmevt_pkg::ACC_NONE;
   end
endmodule

// File: rtl/cmevt_sense.sv
module cmevt_sense #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_in,
   output logic             changed
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_in;
   end

   assign changed = (cnt_in != cnt_q);
endmodule

// File: rtl/cmevt_slot.sv
module cmevt_slot #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             enable,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic             cnt_changed,
   output logic [CNT_W-1:0] value,
   output logic             armed,
   output logic             hit
);
   assign hit = cnt_changed && enable && armed && (cnt_in == value);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
         armed <= 1'b0;
      end else if (wr) begin
         value <= wdata;
         armed <= 1'b1;
      end else if (hit) begin
         armed <= 1'b0;
      end
   end
endmodule

// File: rtl/cmevt_top.sv
module cmevt_top #(
   parameter int ADDR_W    = 8,
   parameter int CNT_W     = 32,
   parameter int NUM_CMP   = 8,
   parameter int SLOT_BASE = 'h60,
   parameter int EN_OFF    = 'h80,
   parameter cmevt_pkg::cmevt_irq_style_e IRQ_STYLE = cmevt_pkg::IRQ_REGISTERED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  count_in,
   output logic              cmp_irq
);
   localparam int SLOT_END = SLOT_BASE + 4 * NUM_CMP;

   if (NUM_CMP < 1 || NUM_CMP > CNT_W) begin : g_bad_count
      $error("cmevt_top: NUM_CMP must lie in 1..CNT_W");
   end
   if (SLOT_END > EN_OFF && EN_OFF >= SLOT_BASE) begin : g_bad_map
      $error("cmevt_top: enable register overlaps the compare slots");
   end
   if (SLOT_END > (1 << ADDR_W) || EN_OFF >= (1 << ADDR_W)) begin : g_bad_addr
      $error("cmevt_top: register map exceeds the address width");
   end

   logic [NUM_CMP-1:0] sel_slot;
   logic               sel_en;
   cmevt_pkg::cmevt_acc_e acc_kind;
   logic [NUM_CMP-1:0] wr_oh;
   logic [NUM_CMP-1:0] en_bits;
   logic [NUM_CMP-1:0] armed;
   logic [NUM_CMP-1:0] hit_vec;
   logic [CNT_W-1:0]   slot_val [NUM_CMP];
   logic               cnt_changed;
   logic               hit_any;

   cmevt_decode #(
      .ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP), .SLOT_BASE(SLOT_BASE), .EN_OFF(EN_OFF)
   ) u_decode (
      .addr(bus_addr), .sel_slot(sel_slot), .sel_en(sel_en), .acc_kind(acc_kind)
   );

   cmevt_sense #(.CNT_W(CNT_W)) u_sense (
      .clk(clk), .rst_n(rst_n), .cnt_in(count_in), .changed(cnt_changed)
   );

   assign wr_oh = (bus_wr && acc_kind == cmevt_pkg::ACC_SLOT) ? sel_slot : '0;

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
      cmevt_slot #(.CNT_W(CNT_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_oh[i]), .wdata(bus_wdata),
         .enable(en_bits[i]),
         .cnt_in(count_in), .cnt_changed(cnt_changed),
         .value(slot_val[i]), .armed(armed[i]), .hit(hit_vec[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                       en_bits <= '0;
      else if (bus_wr && acc_kind == cmevt_pkg::ACC_EN) en_bits <= bus_wdata[NUM_CMP-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_en) bus_rdata[NUM_CMP-1:0] = en_bits;
      for (int i = 0; i < NUM_CMP; i++) begin
         if (sel_slot[i]) bus_rdata = slot_val[i];
      end
   end

   assign hit_any = |hit_vec;

   if (IRQ_STYLE == cmevt_pkg::IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit_any;
      end
      assign cmp_irq = irq_q;
   end else begin : g_irq_comb
      assign cmp_irq = hit_any;
   end
endmodule

// File: rtl/cmevt_checker.sv
module cmevt_checker #(
   parameter int CNT_W   = 32,
   parameter int NUM_CMP = 8,
   parameter cmevt_pkg::cmevt_irq_style_e IRQ_STYLE = cmevt_pkg::IRQ_REGISTERED
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmp_irq,
   input logic [CNT_W-1:0]   count_in,
   input logic [NUM_CMP-1:0] armed,
   input logic [NUM_CMP-1:0] en_bits,
   input logic [NUM_CMP-1:0] wr_oh,
   input logic [NUM_CMP-1:0] hit_vec
);
   // R1: no interrupt comes out of a reset cycle
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> !cmp_irq);

   // R2: a write to a slot leaves it armed
   a_r2_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_oh) |=> ((armed & $past(wr_oh)) == $past(wr_oh)));

   // R5: a slot that fires without a concurrent write is disarmed
   a_r5_hit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hit_vec & ~wr_oh)) |=> ((armed & $past(hit_vec & ~wr_oh)) == '0));

   if (IRQ_STYLE == cmevt_pkg::IRQ_REGISTERED) begin : g_reg
      // R6: a pulse needs an armed and enabled slot one cycle earlier
      a_r6_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_irq |-> $past(|(en_bits & armed)));
      // R7: a pulse needs a counter change at the edge before it
      a_r7_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_irq |-> ($past(count_in) != $past(count_in, 2)));
   end else begin : g_comb
      // R6: a pulse needs an armed and enabled slot
      a_r6_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_irq |-> (|(en_bits & armed)));
      // R7: a pulse needs a counter change
      a_r7_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_irq |-> (count_in != $past(count_in)));
   end
endmodule

bind cmevt_top cmevt_checker #(
   .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .IRQ_STYLE(IRQ_STYLE)
) u_checker (
   .clk(clk), .rst_n(rst_n), .cmp_irq(cmp_irq), .count_in(count_in),
   .armed(armed), .en_bits(en_bits), .wr_oh(wr_oh), .hit_vec(hit_vec)
);

// File: tb/cmevt_top_bench.sv
module cmevt_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] count_in = '0;
   logic        cmp_irq;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Reference state kept by the bench
   logic [31:0]   m_cmp [NS];
   logic [NS-1:0] m_en;
   logic [NS-1:0] m_arm;
   logic [31:0]   m_prev;
   logic [31:0]   cur;

   cmevt_top u_cmevt_top (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count_in(count_in), .cmp_irq(cmp_irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [7:0] slot_addr(int i);
      return 8'h60 + 8'(4 * i);
   endfunction

   function automatic logic [31:0] model_read(logic [7:0] a);
      logic [31:0] r = '0;
      if (a == 8'h80) r[NS-1:0] = m_en;
      for (int i = 0; i < NS; i++) if (a == slot_addr(i)) r = m_cmp[i];
      return r;
   endfunction

   function automatic logic model_hit(logic [31:0] c);
      logic h = 1'b0;
      for (int i = 0; i < NS; i++)
         if (c != m_prev && m_en[i] && m_arm[i] && m_cmp[i] == c) h = 1'b1;
      return h;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One clock: drive at negedge, update the reference at the edge, check irq after it.
   task automatic step(bit wr, logic [7:0] a, logic [31:0] d, logic [31:0] c, string tag);
      logic exp_irq;
      bus_wr = wr; bus_addr = a; bus_wdata = d; count_in = c;
      @(posedge clk);
      exp_irq = model_hit(c);
      for (int i = 0; i < NS; i++) begin
         if (c != m_prev && m_en[i] && m_arm[i] && m_cmp[i] == c) m_arm[i] = 1'b0;
         if (wr && a == slot_addr(i)) begin m_cmp[i] = d; m_arm[i] = 1'b1; end
      end
      if (wr && a == 8'h80) m_en = d[NS-1:0];
      m_prev = c;
      cur = c;
      @(negedge clk);
      bus_wr = 1'b0;
      check(tag, {31'd0, cmp_irq}, {31'd0, exp_irq});
   endtask

   task automatic rd(logic [7:0] a, string tag);
      bus_wr = 1'b0; bus_addr = a;
      #1;
      check(tag, bus_rdata, model_read(a));
   endtask

   task automatic hold(int n, string tag);
      for (int k = 0; k < n; k++) step(1'b0, 8'h00, 32'd0, cur, tag);
   endtask

   task automatic count_up(int n, string tag);
      for (int k = 0; k < n; k++) step(1'b0, 8'h00, 32'd0, cur + 32'd1, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NS; i++) m_cmp[i] = '0;
      m_en = '0; m_arm = '0; m_prev = '0; cur = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 irq in reset", {31'd0, cmp_irq}, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < NS; i++) rd(slot_addr(i), "R1 slot reset");
      rd(8'h80, "R1 enable reset");

      // R2: write and read back every slot
      for (int i = 0; i < NS; i++) step(1'b1, slot_addr(i), 32'hA5000000 + 32'(i * 17), cur, "R2 write");
      for (int i = 0; i < NS; i++) rd(slot_addr(i), "R2 readback");
      // R3: upper enable bits read zero
      step(1'b1, 8'h80, 32'hFFFF_FF00, cur, "R3 write");
      rd(8'h80, "R3 upper bits");
      check("R3 literal", bus_rdata, 32'h0);
      // R10: stray writes change nothing
      step(1'b1, 8'h62, 32'h1234_5678, cur, "R10 unaligned");
      step(1'b1, 8'h84, 32'hFFFF_FFFF, cur, "R10 past enable");
      step(1'b1, 8'h5C, 32'hDEAD_BEEF, cur, "R10 below slots");
      for (int i = 0; i < NS; i++) rd(slot_addr(i), "R10 slots intact");
      rd(8'h80, "R10 enable intact");
      rd(8'h62, "R10 unmapped read");
      check("R10 unmapped literal", bus_rdata, 32'h0);

      // R8/R4: wrapped target 0xFFFFFFFD + 5 = 2
      step(1'b0, 8'h00, 32'd0, 32'hFFFF_FFFD, "R8 set count");
      step(1'b1, slot_addr(0), cur + 32'd5, cur, "R8 arm slot0");
      step(1'b1, 8'h80, 32'h0000_0001, cur, "R4 enable slot0");
      count_up(7, "R8 wrap to target");
      // R5: come back to 2 again, no pulse
      step(1'b0, 8'h00, 32'd0, 32'd1, "R5 back");
      step(1'b0, 8'h00, 32'd0, 32'd2, "R5 no refire");
      // R7: write target equal to held count, no pulse
      step(1'b1, slot_addr(0), 32'd2, 32'd2, "R7 arm at current");
      hold(3, "R7 steady");
      step(1'b0, 8'h00, 32'd0, 32'd3, "R7 leave");
      step(1'b0, 8'h00, 32'd0, 32'd2, "R7 return fires");
      // R6: disabled slot keeps arming
      step(1'b1, slot_addr(3), 32'd10, cur, "R6 arm slot3");
      count_up(10, "R6 pass disabled");
      step(1'b0, 8'h00, 32'd0, 32'd9, "R6 back");
      step(1'b1, 8'h80, 32'h0000_0009, cur, "R6 enable slot3");
      step(1'b0, 8'h00, 32'd0, 32'd10, "R6 fires later");
      // R9: two slots on one value, one pulse
      step(1'b1, slot_addr(5), 32'd20, cur, "R9 arm slot5");
      step(1'b1, slot_addr(7), 32'd20, cur, "R9 arm slot7");
      step(1'b1, slot_addr(6), 32'd21, cur, "R9 arm slot6");
      step(1'b1, 8'h80, 32'h0000_00E0, cur, "R9 enable");
      count_up(12, "R9 shared and distinct");
      // R5: write during a match keeps the slot armed
      step(1'b1, slot_addr(5), 32'd40, cur, "R5 arm slot5");
      step(1'b0, 8'h00, 32'd0, 32'd39, "R5 near");
      step(1'b1, slot_addr(5), 32'd41, 32'd40, "R5 write on match");
      step(1'b0, 8'h00, 32'd0, 32'd41, "R5 new value fires");

      // R8/R4 random: count wanders across the wrap with frequent targets
      step(1'b1, 8'h80, 32'h0000_00FF, 32'hFFFF_FFF0, "R8 random start");
      for (int k = 0; k < 3000; k++) begin
         int sel = int'($urandom % 10);
         logic [31:0] nxt = cur + ($urandom % 3);
         if (sel < 3)
            step(1'b1, slot_addr(int'($urandom % NS)), cur + ($urandom % 6), nxt, "R8 random arm");
         else if (sel == 3)
            step(1'b1, 8'h80, $urandom, nxt, "R6 random enable");
         else
            step(1'b0, 8'h00, 32'd0, nxt, "R4 random run");
      end
      for (int i = 0; i < NS; i++) rd(slot_addr(i), "R2 final readback");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule